// File: doc/BRIEF.md
# Four-Channel Chainable Compare Timer

This block holds four 16-bit timers for a peripheral subsystem. Each timer counts ticks from a source chosen in its control register: every system clock, one system clock in sixteen, rising edges of its own input pin, or the reference match of the timer before it. When the count reaches the programmed reference, the timer drives its output pin and sets a sticky event flag. On the tick after the match, the count returns to zero.

The output pin can give a one-clock active-low pulse on each match, or it can change level on each match. The input pin can also load the current count into a capture register on a rising edge, a falling edge or either edge. Timer *i* can take timer *i-1* as its tick source, and timer 0 takes timer 3. When two timers are chained this way they form one 32-bit timer, and the lower timer's pin keeps working as usual.

Software reaches the timers through a single-cycle write port and a combinational read port. The address bits [4:3] select the timer and the bits [2:0] select the register.

Top module: `timer_quad`

## Requirements
- R1: After reset every control, reference, count, capture and flag register reads 0, every `tout` pin is 1 and every event pin is 0.
- R2: Register map per timer: 0 control, 1 reference, 2 count (a write loads it), 3 capture, 4 flags (bit0 reference event, bit1 capture event). While enabled, the count goes cnt → (cnt==ref ? 0 : cnt+1) on each tick, so after k ticks from 0 it equals k mod (ref+1).
- R3: Control bit3=0 selects pulse output: `tout` is low for exactly one system clock each time the count becomes equal to the reference.
- R4: Control bit3=1 selects toggle output: `tout` inverts on each match. Whenever control bit0 (enable) is 0, `tout` returns to 1.
- R5: A match sets flag bit0, which stays set until a write of 1 to that bit. Writing 0 leaves the flag unchanged. The flag is mirrored on `ref_evt`.
- R6: Control bits[2:1]=1 count one tick every 16 system clocks.
- R7: Control bits[2:1]=2 count rising edges of the timer's own `tin` pin, taken after a two-stage synchronizer. Bits[2:1]=0 count every system clock.
- R8: Control bits[5:4] pick the capture edge: 0 none, 1 rising, 2 falling, 3 both. On the chosen edge the current count is copied into the capture register, whether the timer is enabled or not.
- R9: A capture sets flag bit1, which is cleared by writing 1 and mirrored on `cap_evt`.
- R10: Control bits[2:1]=3 advance timer i once per reference match of timer (i-1) mod 4, one clock after that match. The lower timer's pin behaves as without the chain.
- R11: While a timer is disabled, its count holds its value except when software writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Timer select [4:3], register select [2:0] |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| tin | input | 4 | Timer input pins |
| tout | output | 4 | Timer output pins |
| ref_evt | output | 4 | Sticky reference-event flags |
| cap_evt | output | 4 | Sticky capture-event flags |

## Verification
On every cycle the assertions check that the count wraps to zero at the reference, that a disabled timer holds its count and drives its pin high, that event flags stay set until cleared, that a capture always raises its flag, and that prescaler ticks never come back to back. Only the bench scenarios can show the numbers: the count after a known number of ticks, the number of low output cycles in pulse and toggle modes, the captured values for each edge selection, the tick rate of the divided source, and the count of a chained upper timer.

// File: rtl/tq_pkg.sv
package tq_pkg;
  typedef enum logic [1:0] {
    SRC_SYS  = 2'd0,
    SRC_DIV  = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_CHN  = 2'd3
  } src_sel_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e cap_edge;
    logic      toggle;
    src_sel_e  src;
    logic      en;
  } tctrl_t;

  localparam int unsigned CTRL_W = $bits(tctrl_t);
endpackage

// File: rtl/tq_prescale.sv
module tq_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = (pc_q == LAST) ? '0 : pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign tick_o = (pc_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tq_insync.sv
module tq_insync #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
  assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/tq_timer.sv
module tq_timer
  import tq_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_ref,
  input  logic          wr_cnt,
  input  logic          clr_ref,
  input  logic          clr_cap,
  input  logic [CW-1:0] wdata,
  input  logic          pre_tick,
  input  logic          chain_tick,
  input  logic          pin_rise,
  input  logic          pin_fall,
  output tctrl_t        ctrl_o,
  output logic [CW-1:0] ref_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          ref_evt_o,
  output logic          cap_evt_o,
  output logic          tout_o,
  output logic          hit_o
);
  tctrl_t        ctrl_q, ctrl_d;
  logic [CW-1:0] ref_q, ref_d, cnt_q, cnt_d, cap_q, cap_d, cnt_adv;
  logic          ref_evt_q, ref_evt_d, cap_evt_q, cap_evt_d;
  logic          out_q, out_d, hit_q;
  logic          src_tick, tick, hit, cap_fire;

  always_comb begin
    unique case (ctrl_q.src)
      SRC_SYS: src_tick = 1'b1;
      SRC_DIV: src_tick = pre_tick;
      SRC_PIN: src_tick = pin_rise;
      default: src_tick = chain_tick;
    endcase
    tick    = ctrl_q.en & src_tick;
    cnt_adv = (cnt_q == ref_q) ? '0 : cnt_q + 1'b1;
    hit     = tick & ~wr_cnt & (cnt_adv == ref_q);

    unique case (ctrl_q.cap_edge)
      EDGE_RISE: cap_fire = pin_rise;
      EDGE_FALL: cap_fire = pin_fall;
      EDGE_ANY:  cap_fire = pin_rise | pin_fall;
      default:   cap_fire = 1'b0;
    endcase

    ctrl_d    = wr_ctrl ? tctrl_t'(wdata[CTRL_W-1:0]) : ctrl_q;
    ref_d     = wr_ref ? wdata : ref_q;
    cnt_d     = wr_cnt ? wdata : (tick ? cnt_adv : cnt_q);
    cap_d     = cap_fire ? cnt_q : cap_q;
    ref_evt_d = hit | (ref_evt_q & ~clr_ref);
    cap_evt_d = cap_fire | (cap_evt_q & ~clr_cap);

    if (!ctrl_q.en)         out_d = 1'b1;
    else if (ctrl_q.toggle) out_d = out_q ^ hit;
    else                    out_d = ~hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      ref_q     <= '0;
      cnt_q     <= '0;
      cap_q     <= '0;
      ref_evt_q <= 1'b0;
      cap_evt_q <= 1'b0;
      out_q     <= 1'b1;
      hit_q     <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      ref_q     <= ref_d;
      cnt_q     <= cnt_d;
      cap_q     <= cap_d;
      ref_evt_q <= ref_evt_d;
      cap_evt_q <= cap_evt_d;
      out_q     <= out_d;
      hit_q     <= hit;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign ref_o     = ref_q;
  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign ref_evt_o = ref_evt_q;
  assign cap_evt_o = cap_evt_q;
  assign tout_o    = out_q;
  assign hit_o     = hit_q;

  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && cnt_q == ref_q) |=> (cnt_q == '0));

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en) |=> tout_o);

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_evt_o && !clr_ref) |=> ref_evt_o);

  assert_cap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_evt_o);

  assert_hold_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_cnt) |=> $stable(cnt_o));
endmodule

// File: rtl/timer_quad.sv
module timer_quad
  import tq_pkg::*;
#(
  parameter int unsigned NT  = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned DIV = 16,
  parameter int unsigned AW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [NT-1:0] tin,
  output logic [NT-1:0] tout,
  output logic [NT-1:0] ref_evt,
  output logic [NT-1:0] cap_evt
);
  localparam int unsigned RSW = 3;
  localparam int unsigned IW  = AW - RSW;

  logic          rs1_q, rs2_q;
  logic          pre_tick;
  logic [NT-1:0] pin_rise, pin_fall, hit;
  logic [IW-1:0] sel_t;
  logic [RSW-1:0] sel_r;
  tctrl_t        ctrl_a [NT];
  logic [CW-1:0] ref_a  [NT];
  logic [CW-1:0] cnt_a  [NT];
  logic [CW-1:0] cap_a  [NT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  assign sel_t = addr[AW-1:RSW];
  assign sel_r = addr[RSW-1:0];

  tq_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rs2_q), .tick_o(pre_tick)
  );

  tq_insync #(.N(NT)) u_sync (
    .clk(clk), .rst_n(rs2_q), .pin_i(tin), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  generate
    for (genvar i = 0; i < NT; i++) begin : g_tmr
      localparam int unsigned LOWER = (i + NT - 1) % NT;
      logic hit_sel;
      assign hit_sel = wr_en && (sel_t == IW'(i));
      tq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rs2_q),
        .wr_ctrl(hit_sel && sel_r == 3'd0),
        .wr_ref (hit_sel && sel_r == 3'd1),
        .wr_cnt (hit_sel && sel_r == 3'd2),
        .clr_ref(hit_sel && sel_r == 3'd4 && wdata[0]),
        .clr_cap(hit_sel && sel_r == 3'd4 && wdata[1]),
        .wdata(wdata), .pre_tick(pre_tick), .chain_tick(hit[LOWER]),
        .pin_rise(pin_rise[i]), .pin_fall(pin_fall[i]),
        .ctrl_o(ctrl_a[i]), .ref_o(ref_a[i]), .cnt_o(cnt_a[i]), .cap_o(cap_a[i]),
        .ref_evt_o(ref_evt[i]), .cap_evt_o(cap_evt[i]),
        .tout_o(tout[i]), .hit_o(hit[i])
      );
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NT; i++) begin
      if (sel_t == IW'(i)) begin
        unique case (sel_r)
          3'd0:    rdata = CW'(ctrl_a[i]);
          3'd1:    rdata = ref_a[i];
          3'd2:    rdata = cnt_a[i];
          3'd3:    rdata = cap_a[i];
          3'd4:    rdata = CW'({cap_evt[i], ref_evt[i]});
          default: rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/tb_timer_quad.sv
module tb_timer_quad;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  tin;
  logic [3:0]  tout, ref_evt, cap_evt;

  typedef struct {
    logic [15:0] lo;
    logic [15:0] hi;
    bit          direct;
    logic [15:0] act;
    string       tag;
  } item_t;

  item_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  timer_quad dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tin(tin), .tout(tout), .ref_evt(ref_evt), .cap_evt(cap_evt)
  );

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      logic [15:0] a;
      it = sbq.pop_front();
      a = it.direct ? it.act : rdata;
      n_chk++;
      if (a < it.lo || a > it.hi) begin
        n_bad++;
        $display("FAIL %s: got %0h expected %0h..%0h", it.tag, a, it.lo, it.hi);
      end
    end
  end

  task automatic wr(input logic [1:0] t, input logic [2:0] r, input logic [15:0] d);
    wr_en = 1'b1; addr = {t, r}; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic exp_rd(input logic [1:0] t, input logic [2:0] r,
                        input logic [15:0] lo, input logic [15:0] hi, input string tag);
    item_t it;
    addr = {t, r};
    it.lo = lo; it.hi = hi; it.direct = 0; it.act = '0; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); @(posedge clk); #1;
  endtask

  task automatic exp_val(input logic [15:0] act, input logic [15:0] e, input string tag);
    item_t it;
    it.lo = e; it.hi = e; it.direct = 1; it.act = act; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk); @(posedge clk); #1;
  endtask

  task automatic lows(input int idx, input int n, input int e, input string tag);
    int c = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tout[idx] == 1'b0) c++;
    end
    @(posedge clk); #1;
    exp_val(16'(c), 16'(e), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pin(input int idx, input logic v);
    tin[idx] = v;
    idle(6);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; tin = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    exp_rd(0, 0, 0, 0, "R1 ctrl0");
    exp_rd(2, 2, 0, 0, "R1 cnt2");
    exp_rd(3, 3, 0, 0, "R1 cap3");
    exp_val({12'd0, tout}, 16'hF, "R1 tout");
    exp_val({8'd0, ref_evt, cap_evt}, 16'h0, "R1 flags");

    // R2 wrap count, R3 pulse output
    wr(0, 1, 16'd4);
    wr(0, 0, 16'h0001);
    idle(7);
    exp_rd(0, 2, 16'd2, 16'd2, "R2 count mod ref+1");
    lows(0, 20, 4, "R3 one-clock pulses");
    exp_rd(0, 4, 16'd1, 16'd1, "R5 ref flag set");
    exp_val({15'd0, ref_evt[0]}, 16'd1, "R5 ref_evt pin");

    // R11 hold while disabled, R4 idle high
    wr(0, 0, 16'h0000);
    wr(0, 2, 16'd3);
    idle(10);
    exp_rd(0, 2, 16'd3, 16'd3, "R11 count held");
    exp_val({15'd0, tout[0]}, 16'd1, "R4 disabled high");

    // R5 write-one-to-clear
    wr(0, 4, 16'h0000);
    exp_rd(0, 4, 16'd1, 16'd1, "R5 write 0 keeps flag");
    wr(0, 4, 16'h0001);
    exp_rd(0, 4, 16'd0, 16'd0, "R5 write 1 clears");

    // R4 toggle output
    wr(0, 2, 16'd0);
    wr(0, 1, 16'd2);
    wr(0, 0, 16'h0009);
    lows(0, 12, 6, "R4 toggle duty");
    wr(0, 0, 16'h0000);
    idle(2);
    exp_val({15'd0, tout[0]}, 16'd1, "R4 toggle reset high");

    // R6 divide by 16
    wr(1, 1, 16'hFFFF);
    wr(1, 2, 16'd0);
    wr(1, 0, 16'h0003);
    idle(160);
    exp_rd(1, 2, 16'd9, 16'd10, "R6 prescaled ticks");
    wr(1, 0, 16'h0000);

    // R7 pin clock
    wr(2, 1, 16'hFFFF);
    wr(2, 2, 16'd0);
    wr(2, 0, 16'h0005);
    for (int k = 0; k < 5; k++) begin
      pin(2, 1'b1);
      pin(2, 1'b0);
    end
    exp_rd(2, 2, 16'd5, 16'd5, "R7 pin edges counted");
    wr(2, 0, 16'h0000);

    // R8 capture edges, R9 capture flag
    wr(3, 0, 16'h0010);
    wr(3, 2, 16'h1234);
    pin(3, 1'b1);
    exp_rd(3, 3, 16'h1234, 16'h1234, "R8 rising capture");
    exp_rd(3, 4, 16'd2, 16'd2, "R9 capture flag");
    exp_val({15'd0, cap_evt[3]}, 16'd1, "R9 cap_evt pin");
    pin(3, 1'b0);
    wr(3, 4, 16'h0002);
    wr(3, 0, 16'h0020);
    wr(3, 2, 16'h0055);
    pin(3, 1'b1);
    exp_rd(3, 3, 16'h1234, 16'h1234, "R8 falling ignores rise");
    exp_rd(3, 4, 16'd0, 16'd0, "R9 no flag on ignored edge");
    pin(3, 1'b0);
    exp_rd(3, 3, 16'h0055, 16'h0055, "R8 falling capture");
    wr(3, 0, 16'h0030);
    wr(3, 2, 16'h0077);
    pin(3, 1'b1);
    exp_rd(3, 3, 16'h0077, 16'h0077, "R8 both rise");
    wr(3, 2, 16'h0088);
    pin(3, 1'b0);
    exp_rd(3, 3, 16'h0088, 16'h0088, "R8 both fall");

    // R10 chained timers
    wr(1, 2, 16'd0);
    wr(1, 1, 16'hFFFF);
    wr(1, 0, 16'h0007);
    wr(0, 2, 16'd0);
    wr(0, 1, 16'd3);
    wr(0, 0, 16'h0001);
    idle(41);
    exp_rd(1, 2, 16'd10, 16'd10, "R10 upper counts lower matches");
    lows(0, 20, 5, "R10 lower pin unaffected");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule